// File: doc/BRIEF.md
# Boot-Block Address Decoder with Write Lock

This block maps a word address inside a 2M-word flash array onto the erase block that contains it. The array is split unevenly. One end holds eight small 4K-word parameter blocks. The rest holds 63 large 32K-word main blocks. A build-time parameter picks which end of the address space the small blocks sit at. For every address the block returns four things: the block number, the lowest word address of that block, a flag that marks a small block, and a verdict on whether a program or erase may touch it. An erase engine walks a whole block starting from the returned base address. A command sequencer consults the verdict before it starts the array operation.

The verdict combines two inputs. The first is a write-protect pin, active low, which guards only the two lowest-numbered parameter blocks. The second is a program-voltage-good indication, which is captured into a register on an operation-start strobe. A voltage lockout captured there protects every block until the next start strobe loads a new value. Block numbers count up from the parameter end of the array. In the top-placed variant, block 0 is therefore the highest 4K block.

Top module: `bbd_decoder`

## Requirements
- R1: With the parameter blocks at the top (`TOP_BOOT` = BOOT_TOP), addresses 1FF000h–1FFFFFh decode to block 0 and each lower 4K step down to 1F8000h adds one, up to block 7. Main block 8 is 1F0000h–1F7FFFh, and each lower 32K step adds one, up to block 70 at 000000h.
- R2: With the parameter blocks at the bottom (BOOT_BOTTOM), 4K blocks 0–7 ascend from 000000h to 007FFFh. Main block 8 starts at 008000h and each higher 32K step adds one, up to block 70 at 1F8000h.
- R3: `blk_base_o` is the lowest word address of the decoded block: 4K-aligned for a parameter block, 32K-aligned for a main block. `blk_param_o` is 1 exactly when the block is a 4K block.
- R4: Block number, base and parameter flag follow `addr_i` in the same cycle, with no register on the path.
- R5: The lockout register takes the value of `vpp_ok_i` on each rising clock edge where `op_start_i` is 1. It resets to 0, so after reset `wr_allow_o` is 0 at every address.
- R6: A change of `vpp_ok_i` while `op_start_i` is 0 leaves `wr_allow_o` unchanged.
- R7: While the captured voltage flag is 0, `wr_allow_o` is 0 for all 71 blocks, whatever the level of `wp_n_i`.
- R8: While the captured flag is 1 and `wp_n_i` is 0, `wr_allow_o` is 0 for blocks 0 and 1 and is 1 for blocks 2–70.
- R9: While the captured flag is 1 and `wp_n_i` is 1, `wr_allow_o` is 1 for every block, including blocks 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 21 | Word address to decode |
| wp_n_i | input | 1 | Write-protect level: 0 guards blocks 0 and 1, 1 releases them |
| vpp_ok_i | input | 1 | 1 when the program voltage is above the lockout threshold |
| op_start_i | input | 1 | One-cycle strobe marking the start of a program or erase |
| blk_idx_o | output | 7 | Block number, 0–70 |
| blk_base_o | output | 21 | Lowest word address of the block |
| blk_param_o | output | 1 | 1 for a 4K parameter block |
| wr_allow_o | output | 1 | 1 when a program or erase of this block may proceed |

## Verification
Block number, base and parameter flag are combinational, so they are due in the same cycle as the address. The bench samples them 1 ns after driving, before any clock edge. The write-allow verdict depends on the lockout register, so its new value is due after the first rising edge that sees `op_start_i` high. The driver pushes each expectation into a queue at the falling edge. The monitor pops it 1 ns after the next rising edge, so every comparison of the verdict comes after the register it depends on has loaded. Two instances, one per placement variant, are compared against the same expectation.

// File: rtl/bbd_pkg.sv
package bbd_pkg;
  // Which end of the address space carries the small erase blocks
  typedef enum logic {
    BOOT_BOTTOM = 1'b0,
    BOOT_TOP    = 1'b1
  } boot_side_e;
endpackage

// File: rtl/bbd_index.sv
// Block numbering: the address above the parameter-block offset bits is split
// into a 32K slot number and a 4K sub-slot number; one slot is the parameter region.
module bbd_index
  import bbd_pkg::*;
#(
  parameter int         SLOT_W   = 6,
  parameter int         SUB_W    = 3,
  parameter int         IDX_W    = 7,
  parameter boot_side_e TOP_BOOT = BOOT_TOP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOT_W+SUB_W-1:0] hi_addr_i,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    is_param_o
);
  localparam int N_PARAM   = 1 << SUB_W;
  localparam int N_SLOT    = 1 << SLOT_W;
  localparam int N_BLK     = N_PARAM + N_SLOT - 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOT - 1);

  logic [SLOT_W-1:0] slot;
  logic [SUB_W-1:0]  sub;
  assign slot = hi_addr_i[SLOT_W+SUB_W-1:SUB_W];
  assign sub  = hi_addr_i[SUB_W-1:0];

  // Bottom placement: slot 0 is the parameter region, numbers ascend with address
  function automatic logic [IDX_W-1:0] idx_bottom(input logic [SLOT_W-1:0] s,
                                                  input logic [SUB_W-1:0]  p);
    if (s == '0) return IDX_W'(p);
    return IDX_W'(N_PARAM - 1) + IDX_W'(s);
  endfunction

  // Top placement: last slot is the parameter region, numbers descend with address
  function automatic logic [IDX_W-1:0] idx_top(input logic [SLOT_W-1:0] s,
                                               input logic [SUB_W-1:0]  p);
    if (s == LAST_SLOT) return IDX_W'(N_PARAM - 1) - IDX_W'(p);
    return IDX_W'(N_PARAM) + IDX_W'(LAST_SLOT - 1'b1 - s);
  endfunction

  generate
    if (TOP_BOOT == BOOT_TOP) begin : g_top
      assign is_param_o = (slot == LAST_SLOT);
      assign idx_o      = idx_top(slot, sub);
    end else begin : g_bot
      assign is_param_o = (slot == '0);
      assign idx_o      = idx_bottom(slot, sub);
    end
  endgenerate

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o < IDX_W'(N_BLK)); // R1

  AST_PARAM_LOW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    is_param_o == (idx_o < IDX_W'(N_PARAM))); // R3
endmodule

// File: rtl/bbd_base.sv
// Base address of the decoded block: clear the offset bits for its size
module bbd_base #(
  parameter int ADDR_W  = 21,
  parameter int PARAM_W = 12,
  parameter int MAIN_W  = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_param_i,
  output logic [ADDR_W-1:0] base_o
);
  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input int lg);
    logic [ADDR_W-1:0] mask;
    mask = '1;
    mask = mask << lg;
    return a & mask;
  endfunction

  assign base_o = is_param_i ? align_down(addr_i, PARAM_W)
                             : align_down(addr_i, MAIN_W);
endmodule

// File: rtl/bbd_guard.sv
// Write-permission decision with the captured voltage-lockout flag
module bbd_guard #(
  parameter int IDX_W    = 7,
  parameter int LOCK_CNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vpp_ok_i,
  input  logic             op_start_i,
  input  logic             wp_n_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             vpp_q_o,
  output logic             lockable_o,
  output logic             wr_allow_o
);
  logic vpp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vpp_q <= 1'b0;
    else if (op_start_i) vpp_q <= vpp_ok_i;
  end

  assign vpp_q_o    = vpp_q;
  assign lockable_o = (idx_i < IDX_W'(LOCK_CNT));
  assign wr_allow_o = vpp_q & ~(lockable_o & ~wp_n_i);

  AST_VPP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_i |=> (vpp_q == $past(vpp_ok_i))); // R5

  AST_VPP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start_i |=> $stable(vpp_q)); // R6
endmodule

// File: rtl/bbd_decoder.sv
module bbd_decoder
  import bbd_pkg::*;
#(
  parameter int         ADDR_W   = 21,
  parameter int         PARAM_W  = 12,
  parameter int         MAIN_W   = 15,
  parameter int         LOCK_CNT = 2,
  parameter boot_side_e TOP_BOOT = BOOT_TOP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  input  logic              vpp_ok_i,
  input  logic              op_start_i,
  output logic [6:0]        blk_idx_o,
  output logic [ADDR_W-1:0] blk_base_o,
  output logic              blk_param_o,
  output logic              wr_allow_o
);
  // The parameter region is assumed to fill exactly one main-block slot
  localparam int SUB_W  = MAIN_W - PARAM_W;
  localparam int SLOT_W = ADDR_W - MAIN_W;
  localparam int N_BLK  = (1 << SUB_W) + (1 << SLOT_W) - 1;
  localparam int IDX_W  = $clog2(N_BLK);
  localparam logic [ADDR_W-1:0] PSIZE = ADDR_W'(1) << PARAM_W;
  localparam logic [ADDR_W-1:0] MSIZE = ADDR_W'(1) << MAIN_W;

  logic [IDX_W-1:0]  map_idx;
  logic              map_is_param;
  logic [ADDR_W-1:0] map_base;
  logic              grd_vpp_q;
  logic              grd_lockable;
  logic              grd_allow;

  bbd_index #(
    .SLOT_W(SLOT_W), .SUB_W(SUB_W), .IDX_W(IDX_W), .TOP_BOOT(TOP_BOOT)
  ) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_addr_i  (addr_i[ADDR_W-1:PARAM_W]),
    .idx_o      (map_idx),
    .is_param_o (map_is_param)
  );

  bbd_base #(
    .ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W)
  ) u_base (
    .addr_i     (addr_i),
    .is_param_i (map_is_param),
    .base_o     (map_base)
  );

  bbd_guard #(
    .IDX_W(IDX_W), .LOCK_CNT(LOCK_CNT)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .vpp_ok_i   (vpp_ok_i),
    .op_start_i (op_start_i),
    .wp_n_i     (wp_n_i),
    .idx_i      (map_idx),
    .vpp_q_o    (grd_vpp_q),
    .lockable_o (grd_lockable),
    .wr_allow_o (grd_allow)
  );

  assign blk_idx_o   = 7'(map_idx);
  assign blk_param_o = map_is_param;
  assign blk_base_o  = map_base;
  assign wr_allow_o  = grd_allow;

  AST_BASE_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i >= blk_base_o) &&
    ((addr_i - blk_base_o) < (blk_param_o ? PSIZE : MSIZE))); // R3

  AST_LOCKOUT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !grd_vpp_q |-> !wr_allow_o); // R7

  AST_MAIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (grd_vpp_q && !grd_lockable) |-> wr_allow_o); // R8
endmodule

// File: tb/tb_bbd_decoder.sv
`timescale 1ns/1ps
module tb_bbd_decoder;
  import bbd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] addr = '0;
  logic        wp_n = 1'b1;
  logic        vok = 1'b0;
  logic        start = 1'b0;

  logic [6:0]  t_idx, b_idx;
  logic [20:0] t_base, b_base;
  logic        t_par, b_par, t_ok, b_ok;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit vpp_model = 0;

  always #2 clk = ~clk;

  bbd_decoder #(.TOP_BOOT(BOOT_TOP)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wp_n_i(wp_n), .vpp_ok_i(vok),
    .op_start_i(start), .blk_idx_o(t_idx), .blk_base_o(t_base),
    .blk_param_o(t_par), .wr_allow_o(t_ok));

  bbd_decoder #(.TOP_BOOT(BOOT_BOTTOM)) dut_bot (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wp_n_i(wp_n), .vpp_ok_i(vok),
    .op_start_i(start), .blk_idx_o(b_idx), .blk_base_o(b_base),
    .blk_param_o(b_par), .wr_allow_o(b_ok));

  typedef struct {
    string       req;
    logic [20:0] a;
    int          t_idx, b_idx;
    logic [20:0] t_base, b_base;
    bit          t_par, b_par, t_ok, b_ok;
  } exp_t;
  exp_t q[$];

  // Reference model, written from the address map
  function automatic int m_idx(int a, bit top);
    if (top) begin
      if (a >= 'h1F8000) return ('h1FFFFF - a) / 4096;
      return 8 + ('h1F7FFF - a) / 32768;
    end
    if (a < 'h8000) return a / 4096;
    return 8 + (a - 'h8000) / 32768;
  endfunction

  function automatic bit m_par(int a, bit top);
    return top ? (a >= 'h1F8000) : (a < 'h8000);
  endfunction

  function automatic logic [20:0] m_base(int a, bit top);
    int sz;
    sz = m_par(a, top) ? 4096 : 32768;
    return 21'((a / sz) * sz);
  endfunction

  function automatic bit m_ok(int a, bit top, bit wpn, bit vq);
    if (!vq) return 0;
    if (m_idx(a, top) < 2 && !wpn) return 0;
    return 1;
  endfunction

  task automatic chk(string req, int act, int exp, logic [20:0] a);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%0h expected=%0h", req, a, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge, check the combinational path,
  // then queue the expectation for the sample after the next rising edge
  task automatic step(int a, bit wpn, bit v, bit st, string req);
    exp_t e;
    @(negedge clk);
    addr = 21'(a); wp_n = wpn; vok = v; start = st;
    #1;
    chk("R4", int'(t_idx), m_idx(a, 1), addr);
    chk("R4", int'(b_idx), m_idx(a, 0), addr);
    if (st && rst_n) vpp_model = v;
    e.req = req; e.a = 21'(a);
    e.t_idx = m_idx(a, 1); e.b_idx = m_idx(a, 0);
    e.t_base = m_base(a, 1); e.b_base = m_base(a, 0);
    e.t_par = m_par(a, 1); e.b_par = m_par(a, 0);
    e.t_ok = m_ok(a, 1, wpn, vpp_model); e.b_ok = m_ok(a, 0, wpn, vpp_model);
    q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  // Monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R1", int'(t_idx), e.t_idx, e.a);
        chk("R2", int'(b_idx), e.b_idx, e.a);
        chk("R3", int'(t_base), int'(e.t_base), e.a);
        chk("R3", int'(b_base), int'(e.b_base), e.a);
        chk("R3", int'(t_par), int'(e.t_par), e.a);
        chk("R3", int'(b_par), int'(e.b_par), e.a);
        chk(e.req, int'(t_ok), int'(e.t_ok), e.a);
        chk(e.req, int'(b_ok), int'(e.b_ok), e.a);
      end
    end
  end

  int alist [14] = '{'h000000, 'h000FFF, 'h001000, 'h001FFF, 'h002000,
                     'h007FFF, 'h008000, 'h123456, 'h1F0000, 'h1F7FFF,
                     'h1F8000, 'h1FDFFF, 'h1FE000, 'h1FFFFF};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // Reset state: lockout flag clear, nothing writable (R5)
    step('h1FFFFF, 1, 1, 0, "R5");
    step('h000000, 1, 1, 0, "R5");
    // Load a good voltage flag (R5)
    step('h000000, 1, 1, 1, "R5");
    foreach (alist[i]) step(alist[i], 1, 1, 0, "R9");
    foreach (alist[i]) step(alist[i], 0, 1, 0, "R8");
    // Voltage drops without a start strobe: verdict must hold (R6)
    foreach (alist[i]) step(alist[i], 1, 0, 0, "R6");
    // Start with voltage low: everything locked (R7)
    step('h123456, 1, 0, 1, "R7");
    foreach (alist[i]) step(alist[i], 1, 0, 0, "R7");
    foreach (alist[i]) step(alist[i], 0, 1, 0, "R6");
    // Walk every 32K slot and the parameter sub-blocks
    step('h000000, 1, 1, 1, "R5");
    for (int s = 0; s < 64; s++) step(s * 32768 + 17, 0, 1, 0, "R8");
    for (int p = 0; p < 8; p++) step('h1F8000 + p * 4096 + 5, 0, 1, 0, "R8");
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R4 watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule